// File: doc/BRIEF.md
# Sync-Locked Period Length Quantizer

This block turns a waveform table size and the number of signal cycles packed into that table into a samples-per-period figure, which is later used to build one cycle of the output waveform. The table size is the dividend and the cycle count is the divisor. A bit-serial restoring divider works out the ratio over a fixed number of clocks. The block also reports whether the table size is a whole multiple of the cycle count.

Two modes decide what happens to a ratio that is not a whole number. In sync mode, the fractional ratio is rounded up to the next integer. A cycle built on that length repeats on a whole number of sample clocks, so it keeps a fixed phase against the sample clock's sync output. The cost is a lower output frequency: the sample clock divided by the integer period. For example, at a 200 MHz clock, 66.66 samples become 67 samples and about 2.985 MHz. In exact mode, the ratio is passed on unrounded as unsigned fixed point. A client starts a run with a one-cycle `start` strobe and waits for the one-cycle `done` pulse. The results are held in registers until the next run completes.

Top module: `qz_period_quantizer`

## Requirements
- R1: When table_len is a whole multiple of cycle_cnt, spp_fixed equals the integer quotient in bits [31:16] with bits [15:0] zero, in both modes (for example 4000/40 gives 100.0).
- R2: In sync mode (exact_mode = 0), a ratio with a nonzero fraction is rounded up to the next integer (4066/61 gives 67.0, and 10/40 gives 1.0). Bits [15:0] of spp_fixed are then zero.
- R3: In exact mode (exact_mode = 1), spp_fixed equals floor(table_len * 65536 / cycle_cnt), an unsigned 16.16 value with no rounding.
- R4: exact_div is 1 exactly when table_len modulo cycle_cnt is 0. A table_len of 0 counts as exact.
- R5: done is high for a single cycle. It rises 33 clock cycles after the edge that accepts start, and spp_fixed and exact_div are valid while done is high.
- R6: busy is high from the accepting edge until done rises. A start seen while busy is high is ignored, and the running operands are kept.
- R7: A start with cycle_cnt = 0 while idle sets div_error at that edge. It produces no done and leaves spp_fixed and exact_div unchanged. The next accepted start clears div_error.
- R8: After reset, spp_fixed, exact_div, busy, done and div_error are all 0.
- R9: exact_mode is sampled on the accepting edge only. Changing it during a run does not affect that run's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a quantization |
| exact_mode | input | 1 | 1 = fixed-point pass-through, 0 = round up to an integer period |
| table_len | input | 16 | Number of samples in the waveform table (dividend) |
| cycle_cnt | input | 16 | Number of signal cycles in the table (divisor) |
| busy | output | 1 | A division is running |
| done | output | 1 | One-cycle pulse when new results are registered |
| div_error | output | 1 | The last request had a zero cycle count |
| exact_div | output | 1 | The last result divided with no remainder |
| spp_fixed | output | 32 | Samples per period, unsigned 16.16 |

## Verification
The corner cases are chosen to expose specific faults:
- The 4066/61 pair gets both a rounding-down sync result of 66 and a wrongly rounded exact result.
- Ratios below one (10/40) and the divisor-equals-dividend and divide-by-one extremes expose remainder and bit-count slips in the divider. A wrong iteration count shifts the 16.16 result by a power of two.
- A second start during a run and a mode flip during a run would corrupt the result if operands or mode were resampled.
- A zero cycle count would leave a spurious done pulse or overwrite the held outputs if the guard were missing.
- An exact latency count catches an off-by-one step counter.

// File: rtl/qz_pkg.sv
package qz_pkg;
   // Mode encoding shared by the quantizer and its bench
   typedef enum logic {
      QZ_SYNC  = 1'b0,
      QZ_EXACT = 1'b1
   } qz_mode_e;

   localparam int QZ_DEF_IN_W   = 16;
   localparam int QZ_DEF_FRAC_W = 16;
endpackage

// File: rtl/qz_restoring_div.sv
module qz_restoring_div #(
   parameter int IN_W   = 16,
   parameter int FRAC_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [IN_W-1:0]          dividend,
   input  logic [IN_W-1:0]          divisor,
   output logic                     busy,
   output logic                     valid,
   output logic [IN_W+FRAC_W-1:0]   quotient
);
   localparam int Q_W   = IN_W + FRAC_W;
   localparam int CNT_W = $clog2(Q_W + 1);

   logic [IN_W-1:0]  rem_q;
   logic [Q_W-1:0]   quo_q;
   logic [IN_W-1:0]  dvs_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             valid_q;

   logic [IN_W:0]    shifted;
   logic [IN_W:0]    diff;
   logic             take;

   // one restoring step: shift in next dividend bit, trial subtract
   always_comb begin
      shifted = {rem_q, quo_q[Q_W-1]};
      diff    = shifted - {1'b0, dvs_q};
      take    = ~diff[IN_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q   <= '0;
         quo_q   <= '0;
         dvs_q   <= '0;
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (load) begin
         rem_q   <= '0;
         quo_q   <= {dividend, {FRAC_W{1'b0}}};
         dvs_q   <= divisor;
         cnt_q   <= CNT_W'(Q_W);
         busy_q  <= 1'b1;
         valid_q <= 1'b0;
      end else if (busy_q) begin
         rem_q   <= take ? diff[IN_W-1:0] : shifted[IN_W-1:0];
         quo_q   <= {quo_q[Q_W-2:0], take};
         cnt_q   <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) begin
            busy_q  <= 1'b0;
            valid_q <= 1'b1;
         end
      end else begin
         valid_q <= 1'b0;
      end
   end

   assign busy     = busy_q;
   assign valid    = valid_q;
   assign quotient = quo_q;

   // partial remainder must stay below the divisor during a run
   assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (rem_q < dvs_q));

   // a run keeps stepping until its count is used up
   assert_run_continues_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !load && cnt_q > CNT_W'(1)) |=> busy_q);
endmodule

// File: rtl/qz_round_stage.sv
module qz_round_stage
   import qz_pkg::*;
#(
   parameter int IN_W   = 16,
   parameter int FRAC_W = 16
) (
   input  logic [IN_W+FRAC_W-1:0] quo_in,
   input  qz_mode_e               mode,
   output logic [IN_W+FRAC_W-1:0] spp_out,
   output logic                   whole
);
   localparam int Q_W = IN_W + FRAC_W;

   logic [IN_W-1:0]   int_part;
   logic [FRAC_W-1:0] frac_part;
   logic [Q_W-1:0]    ceil_val;

   always_comb begin
      int_part  = quo_in[Q_W-1:FRAC_W];
      frac_part = quo_in[FRAC_W-1:0];
      // a nonzero remainder always leaves at least one fraction bit set
      whole     = (frac_part == '0);
      ceil_val  = {int_part + 1'b1, {FRAC_W{1'b0}}};
      if (mode == QZ_EXACT || whole) spp_out = quo_in;
      else                           spp_out = ceil_val;
   end
endmodule

// File: rtl/qz_period_quantizer.sv
module qz_period_quantizer
   import qz_pkg::*;
#(
   parameter int IN_W   = QZ_DEF_IN_W,
   parameter int FRAC_W = QZ_DEF_FRAC_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   exact_mode,
   input  logic [IN_W-1:0]        table_len,
   input  logic [IN_W-1:0]        cycle_cnt,
   output logic                   busy,
   output logic                   done,
   output logic                   div_error,
   output logic                   exact_div,
   output logic [IN_W+FRAC_W-1:0] spp_fixed
);
   localparam int Q_W = IN_W + FRAC_W;

   generate
      if (IN_W < 2) begin : g_bad_in_w
         $error("qz_period_quantizer: IN_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac_w
         $error("qz_period_quantizer: FRAC_W must be at least 1");
      end
   endgenerate

   logic           div_busy;
   logic           div_valid;
   logic [Q_W-1:0] div_quo;
   logic [Q_W-1:0] rnd_spp;
   logic           rnd_whole;
   logic           running;
   logic           accept;
   logic           zero_req;

   qz_mode_e       mode_q;
   logic [Q_W-1:0] spp_q;
   logic           exact_q;
   logic           done_q;
   logic           err_q;

   assign running  = div_busy | div_valid;
   assign accept   = start & ~running & (cycle_cnt != '0);
   assign zero_req = start & ~running & (cycle_cnt == '0);

   qz_restoring_div #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .dividend (table_len),
      .divisor  (cycle_cnt),
      .busy     (div_busy),
      .valid    (div_valid),
      .quotient (div_quo)
   );

   qz_round_stage #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_round (
      .quo_in  (div_quo),
      .mode    (mode_q),
      .spp_out (rnd_spp),
      .whole   (rnd_whole)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= QZ_SYNC;
         spp_q   <= '0;
         exact_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (accept) mode_q <= exact_mode ? QZ_EXACT : QZ_SYNC;
         if (zero_req)    err_q <= 1'b1;
         else if (accept) err_q <= 1'b0;
         done_q <= div_valid;
         if (div_valid) begin
            spp_q   <= rnd_spp;
            exact_q <= rnd_whole;
         end
      end
   end

   assign busy      = running;
   assign done      = done_q;
   assign div_error = err_q;
   assign exact_div = exact_q;
   assign spp_fixed = spp_q;

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   assert_sync_integer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && mode_q == QZ_SYNC) |-> (spp_q[FRAC_W-1:0] == '0));

   assert_exact_has_no_frac_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && exact_q) |-> (spp_q[FRAC_W-1:0] == '0));

   assert_zero_divisor_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      zero_req |=> (err_q && !done_q && $stable(spp_q) && $stable(exact_q)));

   assert_mode_kept_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start) |=> $stable(mode_q));
endmodule

// File: tb/qz_period_quantizer_bench.sv
module qz_period_quantizer_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 12;

   // {exact_mode, table_len, cycle_cnt}
   localparam logic [32:0] VEC [NVEC] = '{
      {1'b0, 16'd4000,  16'd40},
      {1'b1, 16'd4000,  16'd40},
      {1'b0, 16'd4066,  16'd61},
      {1'b1, 16'd4066,  16'd61},
      {1'b0, 16'd10,    16'd40},
      {1'b1, 16'd10,    16'd40},
      {1'b0, 16'd65535, 16'd1},
      {1'b1, 16'd65535, 16'd65535},
      {1'b0, 16'd0,     16'd7},
      {1'b1, 16'd1,     16'd3},
      {1'b0, 16'd65535, 16'd2},
      {1'b1, 16'd3,     16'd65535}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        exact_mode = 1'b0;
   logic [15:0] table_len = '0;
   logic [15:0] cycle_cnt = '0;
   logic        busy, done, div_error, exact_div;
   logic [31:0] spp_fixed;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qz_period_quantizer u_qz_period_quantizer (
      .clk(clk), .rst_n(rst_n), .start(start), .exact_mode(exact_mode),
      .table_len(table_len), .cycle_cnt(cycle_cnt), .busy(busy), .done(done),
      .div_error(div_error), .exact_div(exact_div), .spp_fixed(spp_fixed)
   );

   task automatic check(input bit ok, input string req, input logic [32:0] act,
                        input logic [32:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // {exact flag, 16.16 value} from R1..R4
   function automatic logic [32:0] expect_of(input bit m, input logic [15:0] p,
                                             input logic [15:0] d);
      logic [31:0] q;
      bit ex;
      q  = 32'({p, 16'h0} / {16'h0, d});
      ex = ((p % d) == 16'd0);
      if (!m && !ex) q = {q[31:16] + 16'd1, 16'h0};
      return {ex, q};
   endfunction

   // issues a start, returns the cycle count until done
   task automatic launch(input bit m, input logic [15:0] p, input logic [15:0] d,
                         output int lat);
      @(negedge clk);
      exact_mode = m; table_len = p; cycle_cnt = d; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (lat < 100) begin
         @(posedge clk); lat++; #1;
         if (done) break;
      end
   endtask

   initial begin
      int lat;
      logic [32:0] exp;
      logic [31:0] held;
      bit seen;

      // R8 reset state
      #1;
      check({spp_fixed, exact_div, busy, done, div_error} == '0, "R8",
            33'({spp_fixed, busy, done, div_error}), 33'd0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // vector walk: R1 R2 R3 R4 R5
      for (int i = 0; i < NVEC; i++) begin
         launch(VEC[i][32], VEC[i][31:16], VEC[i][15:0], lat);
         exp = expect_of(VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
         check({exact_div, spp_fixed} == exp, "R1/R2/R3/R4 value",
               {exact_div, spp_fixed}, exp);
         check(lat == 33, "R5 latency", 33'(lat), 33'd33);
         @(posedge clk); #1;
         check(done == 1'b0, "R5 single pulse", 33'(done), 33'd0);
      end

      // R2 explicit: 4066/61 sync -> 67.0
      launch(1'b0, 16'd4066, 16'd61, lat);
      check(spp_fixed == 32'h0043_0000, "R2 round up", 33'(spp_fixed), 33'h0043_0000);
      // R3 explicit: 4066/61 exact -> 0x0042A7DE
      launch(1'b1, 16'd4066, 16'd61, lat);
      check(spp_fixed == 32'h0042_A7DE, "R3 fixed point", 33'(spp_fixed), 33'h0042_A7DE);

      // R6: busy during run, second start ignored
      @(negedge clk);
      exact_mode = 1'b0; table_len = 16'd4000; cycle_cnt = 16'd40; start = 1'b1;
      @(posedge clk); @(negedge clk); start = 1'b0;
      repeat (4) @(posedge clk);
      #1 check(busy == 1'b1, "R6 busy", 33'(busy), 33'd1);
      @(negedge clk);
      table_len = 16'd9; cycle_cnt = 16'd2; start = 1'b1;
      @(negedge clk); start = 1'b0;
      lat = 0;
      while (!done && lat < 100) begin @(posedge clk); lat++; #1; end
      check(spp_fixed == 32'h0064_0000, "R6 ignored start", 33'(spp_fixed), 33'h0064_0000);
      @(posedge clk); #1;
      check(busy == 1'b0, "R6 idle after done", 33'(busy), 33'd0);

      // R9: mode flipped mid-run does not matter
      @(negedge clk);
      exact_mode = 1'b0; table_len = 16'd4066; cycle_cnt = 16'd61; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      exact_mode = 1'b1;
      lat = 0;
      while (!done && lat < 100) begin @(posedge clk); lat++; #1; end
      check(spp_fixed == 32'h0043_0000, "R9 mode latched", 33'(spp_fixed), 33'h0043_0000);

      // R7: zero cycle count
      held = spp_fixed;
      @(negedge clk);
      exact_mode = 1'b1; table_len = 16'd100; cycle_cnt = 16'd0; start = 1'b1;
      @(posedge clk); #1;
      check(div_error == 1'b1, "R7 error set", 33'(div_error), 33'd1);
      check(busy == 1'b0, "R7 no run", 33'(busy), 33'd0);
      @(negedge clk); start = 1'b0;
      seen = 1'b0;
      repeat (40) begin @(posedge clk); #1; if (done) seen = 1'b1; end
      check(!seen, "R7 no done", 33'(seen), 33'd0);
      check(spp_fixed == held, "R7 output held", 33'(spp_fixed), 33'(held));
      launch(1'b1, 16'd8, 16'd4, lat);
      check(div_error == 1'b0, "R7 error cleared", 33'(div_error), 33'd0);
      check(spp_fixed == 32'h0002_0000 && exact_div, "R7 next run",
            {exact_div, spp_fixed}, {1'b1, 32'h0002_0000});

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule